// File: doc/BRIEF.md
# Bus-Width Conversion I/O Bridge

This block sits between a 128-bit system bus master and a single narrower peripheral bus, 32 or 64 bits wide as chosen by a parameter. It has no registers that software can address and needs no set-up, so software never sees it. It only converts data width. Each access pays one clock cycle going down and one clock cycle coming back.

A request from the master is captured into one register stage. From the master's write data and byte enables the bridge keeps only the slave lane that the low address bits name. The slave strobe stays high until the slave acknowledges. The slave's read data, acknowledge and error flag then pass through a second register stage. On the way back the narrow read data is copied into every lane of the 128-bit return bus, so the master can read whichever lane it addressed. The bridge handles one access at a time. A master holds its request until it sees the acknowledge, then drops it.

Top module: `iobr_bridge`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `s_stb`, `m_ack` and `m_err` are 0 and `m_dat_r` is all zeros.
- R2: A request seen on a clock edge while the bridge is idle raises `s_stb` in the very next cycle.
- R3: Once raised, `s_stb` stays high until a clock edge where `s_ack` is 1. Until then `s_adr`, `s_sel`, `s_dat_w` and `s_we` keep the values captured at acceptance, whatever the master drives in the meantime.
- R4: An edge with `s_stb` and `s_ack` both high drops `s_stb` and raises `m_ack` for exactly one cycle. A slave that acknowledges N cycles after the strobe rises therefore gives `m_ack` N+2 cycles after the request edge.
- R5: Lane selection for reads and single-lane writes: the lane index is `m_adr[3:2]` for a 32-bit slave and `m_adr[3]` for a 64-bit slave. Lane k of `m_dat_w` and of `m_sel` is bits [k*W +: W] and [k*W/8 +: W/8], where W is the slave width. That lane is forwarded on `s_dat_w` and `s_sel`.
- R6: The read data returned with `m_ack` equals the slave's `s_dat_r` from the acknowledging edge, copied into every lane of `m_dat_r`.
- R7: `m_err` is high exactly in the `m_ack` cycle that follows a slave acknowledge with `s_err` high. Otherwise it is 0.
- R8: A write whose byte enables cover more than one slave lane forwards only the lowest lane that has any enable set. This holds whatever the address lane bits say. `s_adr` carries that lane's index in its lane bits.
- R9: A request held high across the `m_ack` cycle edge is not accepted as a new access, and `s_stb` stays low in the following cycle.
- R10: `s_adr` equals `m_adr` except for the lane-index bits. Those bits carry the forwarded lane, and the byte offset within the lane passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request, held until `m_ack` |
| m_we | input | 1 | Master write (1) or read (0) |
| m_adr | input | ADDR_W | Master byte address |
| m_sel | input | MASTER_W/8 | Master byte enables |
| m_dat_w | input | MASTER_W | Master write data |
| m_ack | output | 1 | One-cycle completion to the master |
| m_err | output | 1 | Error flag returned with `m_ack` |
| m_dat_r | output | MASTER_W | Read data, slave word copied into every lane |
| s_stb | output | 1 | Slave strobe, held until `s_ack` |
| s_we | output | 1 | Slave write enable |
| s_adr | output | ADDR_W | Slave address with the lane index inserted |
| s_sel | output | SLAVE_W/8 | Slave byte enables |
| s_dat_w | output | SLAVE_W | Slave write data |
| s_ack | input | 1 | Slave acknowledge |
| s_err | input | 1 | Slave error flag, valid with `s_ack` |
| s_dat_r | input | SLAVE_W | Slave read data |

## Verification
A bad control state shows up at once in the cycle count. A bridge that fails to return to idle never raises `s_stb` for the next access. One that re-accepts during the acknowledge cycle raises `s_stb` a cycle early. One that lets `s_stb` fall before the acknowledge loses the completion altogether. Each of these is caught within one or two cycles of the request. A wrong lane choice or a capture register that is not held shows on the slave pins in the same cycle as the strobe. A wrong return register shows on `m_dat_r` or `m_err` in the single `m_ack` cycle.

// File: rtl/iobr_pkg.sv
package iobr_pkg;

   // control state of the single outstanding access
   typedef enum logic [1:0] {
      BR_IDLE = 2'd0,   // free to accept a master request
      BR_WAIT = 2'd1,   // strobe out, waiting for the slave
      BR_DONE = 2'd2    // master acknowledge cycle, refuse new work
   } br_state_e;

   // number of lanes a wide word splits into
   function automatic int unsigned lane_count(input int unsigned wide_w, input int unsigned narrow_w);
      return wide_w / narrow_w;
   endfunction

endpackage

// File: rtl/iobr_lane_pick.sv
module iobr_lane_pick #(
   parameter int unsigned MASTER_W = 128,
   parameter int unsigned SLAVE_W  = 32,
   parameter int unsigned ADDR_W   = 32
) (
   input  logic                    we,
   input  logic [ADDR_W-1:0]       adr,
   input  logic [MASTER_W/8-1:0]   sel,
   input  logic [MASTER_W-1:0]     dat,
   output logic [ADDR_W-1:0]       n_adr,
   output logic [SLAVE_W/8-1:0]    n_sel,
   output logic [SLAVE_W-1:0]      n_dat
);
   localparam int unsigned SB     = SLAVE_W / 8;
   localparam int unsigned LANES  = iobr_pkg::lane_count(MASTER_W, SLAVE_W);
   localparam int unsigned LSEL_W = $clog2(LANES);
   localparam int unsigned BOFF   = $clog2(SB);
   localparam int unsigned HI_W   = ADDR_W - BOFF - LSEL_W;

   logic [SLAVE_W-1:0] lane_dat [LANES];
   logic [SB-1:0]      lane_sel [LANES];
   logic [LANES-1:0]   lane_act;
   logic [LSEL_W-1:0]  low_lane;
   logic [LSEL_W-1:0]  adr_lane;
   logic [LSEL_W-1:0]  lane;
   logic               multi;

   // split the wide bus into slave-sized lanes
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_dat[g] = dat[g*SLAVE_W +: SLAVE_W];
      assign lane_sel[g] = sel[g*SB +: SB];
      assign lane_act[g] = |sel[g*SB +: SB];
   end

   // lowest lane carrying any enable
   if (LANES == 2) begin : g_low2
      assign low_lane = lane_act[0] ? 1'b0 : 1'b1;
   end else begin : g_lown
      always_comb begin
         low_lane = '0;
         for (int i = LANES - 1; i >= 0; i--) begin
            if (lane_act[i]) low_lane = LSEL_W'(i);
         end
      end
   end

   assign adr_lane = adr[BOFF +: LSEL_W];
   assign multi    = $countones(lane_act) > 1;
   assign lane     = (we && multi) ? low_lane : adr_lane;

   assign n_dat = lane_dat[lane];
   assign n_sel = lane_sel[lane];
   assign n_adr = {adr[ADDR_W-1 -: HI_W], lane, adr[BOFF-1:0]};

endmodule

// File: rtl/iobr_req_stage.sv
module iobr_req_stage #(
   parameter int unsigned SLAVE_W = 32,
   parameter int unsigned ADDR_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  m_req,
   input  logic                  m_we,
   input  logic [ADDR_W-1:0]     n_adr,
   input  logic [SLAVE_W/8-1:0]  n_sel,
   input  logic [SLAVE_W-1:0]    n_dat,
   input  logic                  s_ack,
   output logic                  s_stb,
   output logic                  s_we,
   output logic [ADDR_W-1:0]     s_adr,
   output logic [SLAVE_W/8-1:0]  s_sel,
   output logic [SLAVE_W-1:0]    s_dat_w
);
   import iobr_pkg::*;

   br_state_e state_q, state_d;
   logic      take;

   assign take = (state_q == BR_IDLE) && m_req;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         BR_IDLE: if (m_req) state_d = BR_WAIT;
         BR_WAIT: if (s_ack) state_d = BR_DONE;
         BR_DONE: state_d = BR_IDLE;
         default: state_d = BR_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BR_IDLE;
         s_we    <= 1'b0;
         s_adr   <= '0;
         s_sel   <= '0;
         s_dat_w <= '0;
      end else begin
         state_q <= state_d;
         if (take) begin
            s_we    <= m_we;
            s_adr   <= n_adr;
            s_sel   <= n_sel;
            s_dat_w <= n_dat;
         end
      end
   end

   assign s_stb = (state_q == BR_WAIT);

   assert_stb_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (s_stb && !s_ack) |=> (s_stb && $stable(s_adr) && $stable(s_sel)
                             && $stable(s_dat_w) && $stable(s_we)));

   assert_stb_start_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_stb) |-> $past(m_req));

endmodule

// File: rtl/iobr_rsp_stage.sv
module iobr_rsp_stage #(
   parameter int unsigned MASTER_W = 128,
   parameter int unsigned SLAVE_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  s_stb,
   input  logic                  s_ack,
   input  logic                  s_err,
   input  logic [SLAVE_W-1:0]    s_dat_r,
   output logic                  m_ack,
   output logic                  m_err,
   output logic [MASTER_W-1:0]   m_dat_r
);
   localparam int unsigned LANES = iobr_pkg::lane_count(MASTER_W, SLAVE_W);

   logic               hit;
   logic [SLAVE_W-1:0] rdat_q;

   assign hit = s_stb && s_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ack  <= 1'b0;
         m_err  <= 1'b0;
         rdat_q <= '0;
      end else begin
         m_ack <= hit;
         m_err <= hit && s_err;
         if (hit) rdat_q <= s_dat_r;
      end
   end

   // copy the narrow word onto every wide lane
   for (genvar g = 0; g < LANES; g++) begin : g_rep
      assign m_dat_r[g*SLAVE_W +: SLAVE_W] = rdat_q;
   end

   assert_ack_follows_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (s_stb && s_ack) |=> m_ack);

   assert_ack_pulse_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      m_ack |=> !m_ack);

   assert_err_with_ack_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      m_err |-> m_ack);

endmodule

// File: rtl/iobr_bridge.sv
module iobr_bridge #(
   parameter int unsigned MASTER_W = 128,
   parameter int unsigned SLAVE_W  = 32,
   parameter int unsigned ADDR_W   = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  m_req,
   input  logic                  m_we,
   input  logic [ADDR_W-1:0]     m_adr,
   input  logic [MASTER_W/8-1:0] m_sel,
   input  logic [MASTER_W-1:0]   m_dat_w,
   output logic                  m_ack,
   output logic                  m_err,
   output logic [MASTER_W-1:0]   m_dat_r,
   output logic                  s_stb,
   output logic                  s_we,
   output logic [ADDR_W-1:0]     s_adr,
   output logic [SLAVE_W/8-1:0]  s_sel,
   output logic [SLAVE_W-1:0]    s_dat_w,
   input  logic                  s_ack,
   input  logic                  s_err,
   input  logic [SLAVE_W-1:0]    s_dat_r
);
   localparam int unsigned SB     = SLAVE_W / 8;
   localparam int unsigned LANES  = iobr_pkg::lane_count(MASTER_W, SLAVE_W);
   localparam int unsigned LSEL_W = $clog2(LANES);
   localparam int unsigned BOFF   = $clog2(SB);

   // elaboration-time parameter checks
   if (SLAVE_W != 32 && SLAVE_W != 64) begin : g_bad_slave
      $error("iobr_bridge: SLAVE_W must be 32 or 64");
   end
   if (MASTER_W != 128) begin : g_bad_master
      $error("iobr_bridge: MASTER_W must be 128");
   end
   if (ADDR_W <= BOFF + LSEL_W) begin : g_bad_addr
      $error("iobr_bridge: ADDR_W too narrow for lane decode");
   end

   logic [ADDR_W-1:0]  n_adr;
   logic [SB-1:0]      n_sel;
   logic [SLAVE_W-1:0] n_dat;

   iobr_lane_pick #(
      .MASTER_W (MASTER_W),
      .SLAVE_W  (SLAVE_W),
      .ADDR_W   (ADDR_W)
   ) u_pick (
      .we    (m_we),
      .adr   (m_adr),
      .sel   (m_sel),
      .dat   (m_dat_w),
      .n_adr (n_adr),
      .n_sel (n_sel),
      .n_dat (n_dat)
   );

   iobr_req_stage #(
      .SLAVE_W (SLAVE_W),
      .ADDR_W  (ADDR_W)
   ) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .m_req   (m_req),
      .m_we    (m_we),
      .n_adr   (n_adr),
      .n_sel   (n_sel),
      .n_dat   (n_dat),
      .s_ack   (s_ack),
      .s_stb   (s_stb),
      .s_we    (s_we),
      .s_adr   (s_adr),
      .s_sel   (s_sel),
      .s_dat_w (s_dat_w)
   );

   iobr_rsp_stage #(
      .MASTER_W (MASTER_W),
      .SLAVE_W  (SLAVE_W)
   ) u_rsp (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_stb   (s_stb),
      .s_ack   (s_ack),
      .s_err   (s_err),
      .s_dat_r (s_dat_r),
      .m_ack   (m_ack),
      .m_err   (m_err),
      .m_dat_r (m_dat_r)
   );

   assert_busy_no_ack_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      m_ack |-> !s_stb);

   assert_pick_active_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && m_we && (|m_sel)) |-> (|n_sel));

endmodule

// File: tb/tb_iobr_bridge.sv
module tb_iobr_bridge;
   localparam int MW = 128;
   localparam int SW = 32;
   localparam int AW = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           m_req = 1'b0, m_we = 1'b0;
   logic [AW-1:0]  m_adr = '0;
   logic [MW/8-1:0] m_sel = '0;
   logic [MW-1:0]  m_dat_w = '0;
   logic           m_ack, m_err;
   logic [MW-1:0]  m_dat_r;
   logic           s_stb, s_we;
   logic [AW-1:0]  s_adr;
   logic [SW/8-1:0] s_sel;
   logic [SW-1:0]  s_dat_w;
   logic           s_ack = 1'b0, s_err = 1'b0;
   logic [SW-1:0]  s_dat_r = '0;

   int tests = 0;
   int fails = 0;
   int slv_waits = 0;
   bit slv_err = 1'b0;
   int slv_cnt = 0;

   typedef struct packed {
      logic          we;
      logic [AW-1:0] adr;
      logic [3:0]    sel;
      logic [SW-1:0] dat;
   } slv_item_t;
   typedef struct packed {
      logic [MW-1:0] dat;
      logic          err;
   } rsp_item_t;

   slv_item_t exp_slv[$];
   rsp_item_t exp_rsp[$];

   iobr_bridge #(.MASTER_W(MW), .SLAVE_W(SW), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n),
      .m_req(m_req), .m_we(m_we), .m_adr(m_adr), .m_sel(m_sel), .m_dat_w(m_dat_w),
      .m_ack(m_ack), .m_err(m_err), .m_dat_r(m_dat_r),
      .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr), .s_sel(s_sel), .s_dat_w(s_dat_w),
      .s_ack(s_ack), .s_err(s_err), .s_dat_r(s_dat_r)
   );

   always #10 clk = ~clk;

   function automatic logic [SW-1:0] slv_word(input logic [AW-1:0] a);
      return {a[15:0] ^ 16'hA5C3, a[31:16]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [MW-1:0] act, input logic [MW-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // slave model: acknowledges after slv_waits cycles of strobe
   initial begin
      forever begin
         @(negedge clk);
         if (s_stb) begin
            if (slv_cnt == slv_waits) begin
               s_ack   = 1'b1;
               s_err   = slv_err;
               s_dat_r = slv_word(s_adr);
               slv_cnt = 0;
            end else begin
               s_ack = 1'b0;
               s_err = 1'b0;
               slv_cnt++;
            end
         end else begin
            s_ack   = 1'b0;
            s_err   = 1'b0;
            slv_cnt = 0;
         end
      end
   end

   // monitor: compare slave-side and master-side results with the queues
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && s_stb && s_ack) begin
            if (exp_slv.size() == 0) begin
               check(1'b0, "R5", "unexpected slave access", MW'(s_adr), '0);
            end else begin
               slv_item_t e;
               e = exp_slv.pop_front();
               check(s_adr === e.adr, "R10", "slave address", MW'(s_adr), MW'(e.adr));
               check(s_sel === e.sel && s_dat_w === e.dat && s_we === e.we, "R5",
                     "slave lane sel/data/we", MW'({s_we, s_sel, s_dat_w}), MW'({e.we, e.sel, e.dat}));
            end
         end
         if (rst_n && m_ack) begin
            if (exp_rsp.size() == 0) begin
               check(1'b0, "R4", "unexpected m_ack", MW'(m_ack), '0);
            end else begin
               rsp_item_t r;
               r = exp_rsp.pop_front();
               check(m_dat_r === r.dat, "R6", "replicated read data", m_dat_r, r.dat);
               check(m_err === r.err, "R7", "error flag", MW'(m_err), MW'(r.err));
            end
         end
      end
   end

   task automatic xfer(input bit we, input logic [AW-1:0] adr, input logic [15:0] sel,
                       input logic [MW-1:0] dat, input int waits, input bit err,
                       input bit scramble, input bit linger);
      logic [3:0] act;
      int lane, cnt, low, k;
      slv_item_t si;
      rsp_item_t ri;
      for (int i = 0; i < 4; i++) act[i] = |sel[i*4 +: 4];
      cnt = $countones(act);
      low = 0;
      for (int i = 3; i >= 0; i--) if (act[i]) low = i;
      lane = (we && cnt > 1) ? low : int'(adr[3:2]);
      si.we  = we;
      si.adr = {adr[31:4], 2'(lane), adr[1:0]};
      si.sel = sel[lane*4 +: 4];
      si.dat = dat[lane*32 +: 32];
      ri.dat = {4{slv_word(si.adr)}};
      ri.err = err;
      exp_slv.push_back(si);
      exp_rsp.push_back(ri);
      @(negedge clk);
      slv_waits = waits;
      slv_err   = err;
      m_req = 1'b1; m_we = we; m_adr = adr; m_sel = sel; m_dat_w = dat;
      @(posedge clk);
      @(negedge clk); #2;
      check(s_stb === 1'b1, "R2", "strobe one cycle after request", MW'(s_stb), MW'(1));
      if (scramble) begin
         m_we = ~we; m_adr = ~adr; m_sel = ~sel; m_dat_w = ~dat;
      end
      k = 0;
      do begin
         @(negedge clk); #2;
         k++;
         if (scramble && !m_ack) begin
            m_adr = adr + 32'(k * 16); m_dat_w = {4{32'(k)}}; m_sel = 16'(k);
         end
      end while (!m_ack && k < 40);
      check(m_ack === 1'b1 && k == waits + 1, "R4", "ack latency (cycles after strobe)",
            MW'(k), MW'(waits + 1));
      if (scramble) check(1'b1, "R3", "captured fields held (compared by monitor)", '0, '0);
      if (linger) begin
         @(negedge clk); #2;
         check(s_stb === 1'b0, "R9", "request held over ack not re-accepted", MW'(s_stb), '0);
         check(m_ack === 1'b0, "R4", "ack is one cycle wide", MW'(m_ack), '0);
         m_req = 1'b0;
      end else begin
         m_req = 1'b0;
         @(negedge clk); #2;
         check(m_ack === 1'b0 && s_stb === 1'b0, "R4", "ack pulse ends, strobe low",
               MW'({m_ack, s_stb}), '0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(s_stb === 1'b0 && m_ack === 1'b0 && m_err === 1'b0 && m_dat_r === '0, "R1",
            "outputs in reset", MW'({s_stb, m_ack, m_err}), '0);
      rst_n = 1'b1;
      @(negedge clk); #2;
      check(s_stb === 1'b0 && m_ack === 1'b0 && m_err === 1'b0, "R1",
            "outputs after reset release", MW'({s_stb, m_ack, m_err}), '0);

      // reads at every lane, varying slave wait states (R5, R6)
      for (int l = 0; l < 4; l++)
         xfer(1'b0, 32'h4000_1200 + 32'(l * 4), 16'h000F << (l * 4),
              {32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h0000_0000}, l, 1'b0, 1'b0, 1'b0);
      // single-lane writes, partial enables, byte offset kept (R5, R10)
      for (int l = 0; l < 4; l++)
         xfer(1'b1, 32'h8000_0040 + 32'(l * 4) + 32'(l), 16'h0006 << (l * 4),
              {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000}, 1, 1'b0, 1'b0, 1'b0);
      // R8: multi-lane writes forward lowest active lane
      xfer(1'b1, 32'h0000_010C, 16'hF0F0, {32'h4444, 32'h3333, 32'h2222, 32'h1111}, 0, 1'b0, 1'b0, 1'b0);
      xfer(1'b1, 32'h0000_0208, 16'hFFFF, {32'h8888, 32'h7777, 32'h6666, 32'h5555}, 2, 1'b0, 1'b0, 1'b0);
      xfer(1'b1, 32'h0000_0300, 16'h1100, {32'hAAAA, 32'h9999, 32'h0F0F, 32'hF0F0}, 0, 1'b0, 1'b0, 1'b0);
      // a multi-lane read still follows the address
      xfer(1'b0, 32'h0000_0408, 16'hFFFF, '0, 0, 1'b0, 1'b0, 1'b0);
      // R7: error returned with ack, then cleared
      xfer(1'b0, 32'h0000_0504, 16'h00F0, '0, 1, 1'b1, 1'b0, 1'b0);
      xfer(1'b0, 32'h0000_0504, 16'h00F0, '0, 0, 1'b0, 1'b0, 1'b0);
      // R3: master inputs change while waiting
      xfer(1'b1, 32'h1234_5678, 16'h0F00, {32'hCAFE_0003, 32'hCAFE_0002, 32'hCAFE_0001, 32'hCAFE_0000},
           4, 1'b0, 1'b1, 1'b0);
      // R9: request lingers across the ack edge
      xfer(1'b0, 32'h0000_0600, 16'h000F, '0, 0, 1'b0, 1'b0, 1'b1);
      xfer(1'b0, 32'h0000_070C, 16'hF000, '0, 3, 1'b0, 1'b0, 1'b1);
      xfer(1'b1, 32'h0000_0800, 16'h00FF, {32'h0, 32'h0, 32'h5A5A_5A5A, 32'hA5A5_A5A5}, 0, 1'b0, 1'b0, 1'b0);

      repeat (3) @(negedge clk);
      check(exp_slv.size() == 0 && exp_rsp.size() == 0, "R4", "all expected items consumed",
            MW'(exp_slv.size() + exp_rsp.size()), '0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule